// File: doc/BRIEF.md
# Memory Barrier Ordering Gate

This block sits between an in-order stream of memory operations and a single memory port. Each entry carries a tag and a kind: load, store, cache-line zero, instruction-cache invalidate, or barrier. A barrier carries a 2-bit strength code. Data entries also carry three attribute bits: coherence-required, write-through and cache-inhibited. Accesses move to a registered memory port. Each one is later reported as performed by an acknowledge that returns its tag.

The gate counts the issued but unacknowledged accesses, split by epoch and by ordering class. When a barrier has been accepted, a younger access at the head of the stream is held until the older accesses it depends on have been acknowledged. The strong barrier orders every data access. The light barrier orders only loads, stores and zeros whose target is coherent, write-back and cacheable. Under the light barrier a load may still overtake an older store or zero. A barrier retires on its own schedule, independently of the acknowledges. Barriers that arrive while an earlier one is still unresolved fold into a single gate with the stronger strength. A reserved strength code is reported as illegal and has no ordering effect.

Top module: `mem_order_gate`

## Requirements
- R1: After reset the memory port is idle, bar_done, bar_bad and init_stall are low, and with no barrier pending a data access is accepted at once.
- R2: An accepted access appears on the memory port on the next clock with its tag, kind and attributes. It stays there unchanged while mem_ready is low. Kind codes: 0 load, 1 store, 2 zero, 3 instruction-cache invalidate, 4 barrier.
- R3: After a barrier of strength 0, a younger load, store or zero is not accepted until every older load, store and zero has been acknowledged, whatever their attributes.
- R4: Under strength 0 or 2, an older instruction-cache invalidate that has not been acknowledged does not hold a younger data access. A younger invalidate is never held.
- R5: After a barrier of strength 1, a younger covered store or zero waits for all older covered loads, stores and zeros. A younger covered load waits only for older covered loads, so it passes older covered stores and zeros. Covered means coh=1, wt=0, ci=0.
- R6: Under strength 1, a younger access that is not covered (or an invalidate) is accepted at once.
- R7: Under strength 1, older accesses that are not covered never hold a younger covered access.
- R8: A barrier of strength 0 or 2 is not accepted while an older access sits unaccepted on the memory port, and init_stall is high for exactly that time. A strength-1 barrier does not wait for the port.
- R9: A barrier of strength 3 is accepted, raises bar_bad for one cycle with no bar_done, and orders nothing.
- R10: A legal barrier raises bar_done with its tag one cycle after acceptance, even while older accesses are still unacknowledged.
- R11: A barrier accepted while an earlier barrier is still unresolved merges with it. The merged gate takes the stronger strength and orders younger accesses against everything issued before the later barrier.
- R12: Strength 2 orders exactly like strength 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream entry present |
| in_ready | output | 1 | Entry accepted this cycle when high with in_valid |
| in_tag | input | TAG_W | Entry tag |
| in_kind | input | 3 | Entry kind code |
| in_bstr | input | 2 | Barrier strength (barrier entries only) |
| in_coh | input | 1 | Coherence-required attribute |
| in_wt | input | 1 | Write-through attribute |
| in_ci | input | 1 | Cache-inhibited attribute |
| mem_valid | output | 1 | Access offered to memory |
| mem_ready | input | 1 | Memory takes the offered access |
| mem_tag | output | TAG_W | Offered access tag |
| mem_kind | output | 3 | Offered access kind |
| mem_coh | output | 1 | Offered coherence attribute |
| mem_wt | output | 1 | Offered write-through attribute |
| mem_ci | output | 1 | Offered cache-inhibited attribute |
| ack_valid | input | 1 | An access has been performed |
| ack_tag | input | TAG_W | Tag of the performed access |
| bar_done | output | 1 | Legal barrier retired |
| bar_tag | output | TAG_W | Tag of the retired or rejected barrier |
| bar_bad | output | 1 | Reserved barrier strength seen |
| init_stall | output | 1 | Heavy barrier is blocking instruction initiation |

## Verification
A wrong class or epoch in the per-tag table, or a counter that drifts, shows up at in_ready on the first younger access that the barrier guards. It is either accepted while its older dependency is still unacknowledged, or it stays blocked after the last acknowledge. Either error is visible one cycle after the acknowledge. The sweeps cross every older kind and attribute variant with every younger kind under each strength, so a mixed-up class shows up as a wrong ready value in a specific cell of the sweep. A merge or epoch error only becomes visible when a second barrier arrives before the first one resolves, so that case is driven on purpose.

// File: rtl/mog_pkg.sv
`timescale 1ns/1ps
package mog_pkg;
  localparam logic [2:0] K_LOAD  = 3'd0;
  localparam logic [2:0] K_STORE = 3'd1;
  localparam logic [2:0] K_ZERO  = 3'd2;
  localparam logic [2:0] K_ICINV = 3'd3;
  localparam logic [2:0] K_BAR   = 3'd4;

  // ordering classes kept by the tracker
  localparam logic [1:0] CLS_LDO = 2'd0; // covered load
  localparam logic [1:0] CLS_STO = 2'd1; // covered store or zero
  localparam logic [1:0] CLS_OTH = 2'd2; // any other data access
  localparam logic [1:0] CLS_ICI = 2'd3; // icache invalidate
  localparam int NCLS = 4;
  localparam int NEP  = 2;
endpackage

// File: rtl/mog_classify.sv
`timescale 1ns/1ps
module mog_classify
  import mog_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       coh,
  input  logic       wt,
  input  logic       ci,
  output logic       is_bar,
  output logic [1:0] cls
);
  logic covered;
  assign covered = coh & ~wt & ~ci;
  assign is_bar  = (kind == K_BAR);

  always_comb begin
    if (kind == K_ICINV)
      cls = CLS_ICI;
    else if (covered && kind == K_LOAD)
      cls = CLS_LDO;
    else if (covered && (kind == K_STORE || kind == K_ZERO))
      cls = CLS_STO;
    else
      cls = CLS_OTH;
  end
endmodule

// File: rtl/mog_track.sv
`timescale 1ns/1ps
module mog_track
  import mog_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_v,
  input  logic [TAG_W-1:0] inc_tag,
  input  logic [1:0]       inc_cls,
  input  logic             inc_ep,
  input  logic             dec_v,
  input  logic [TAG_W-1:0] dec_tag,
  input  logic [NEP-1:0]   mask,
  output logic [NCLS-1:0]  zero_cls
);
  localparam int DEPTH = 1 << TAG_W;
  localparam int CW    = TAG_W + 1;

  logic [2:0]    tbl [DEPTH];
  logic [CW-1:0] cnt [NEP][NCLS];
  logic [2:0]    dent;
  logic          dep;
  logic [1:0]    dcls;
  logic [NEP-1:0][NCLS-1:0] up, dn;

  // per-tag record {epoch, class}, plain RAM without reset
  always_ff @(posedge clk) begin
    if (inc_v) tbl[inc_tag] <= {inc_ep, inc_cls};
  end

  assign dent = tbl[dec_tag];
  assign dep  = dent[2];
  assign dcls = dent[1:0];

  always_comb begin
    for (int e = 0; e < NEP; e++) begin
      for (int c = 0; c < NCLS; c++) begin
        up[e][c] = inc_v && (inc_ep == 1'(e)) && (inc_cls == 2'(c));
        dn[e][c] = dec_v && (dep == 1'(e)) && (dcls == 2'(c));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NEP; e++)
        for (int c = 0; c < NCLS; c++)
          cnt[e][c] <= '0;
    end else begin
      for (int e = 0; e < NEP; e++)
        for (int c = 0; c < NCLS; c++) begin
          if (up[e][c] && !dn[e][c])
            cnt[e][c] <= cnt[e][c] + 1'b1;
          else if (dn[e][c] && !up[e][c])
            cnt[e][c] <= cnt[e][c] - 1'b1;
        end
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      zero_cls[c] = 1'b1;
      for (int e = 0; e < NEP; e++)
        if (mask[e] && cnt[e][c] != '0) zero_cls[c] = 1'b0;
    end
  end

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec_v |-> cnt[dep][dcls] != '0);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    inc_v |-> cnt[inc_ep][inc_cls] != '1);
endmodule

// File: rtl/mog_outreg.sv
`timescale 1ns/1ps
module mog_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] q,
  output logic         free
);
  assign free = ~valid | ready;

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else if (load) valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

  // R2
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(q)));
endmodule

// File: rtl/mem_order_gate.sv
`timescale 1ns/1ps
module mem_order_gate
  import mog_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [2:0]       in_kind,
  input  logic [1:0]       in_bstr,
  input  logic             in_coh,
  input  logic             in_wt,
  input  logic             in_ci,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [TAG_W-1:0] mem_tag,
  output logic [2:0]       mem_kind,
  output logic             mem_coh,
  output logic             mem_wt,
  output logic             mem_ci,
  input  logic             ack_valid,
  input  logic [TAG_W-1:0] ack_tag,
  output logic             bar_done,
  output logic [TAG_W-1:0] bar_tag,
  output logic             bar_bad,
  output logic             init_stall
);
  localparam int PW = TAG_W + 6;

  logic            is_bar;
  logic [1:0]      cls;
  logic [NCLS-1:0] zc;
  logic            slot_free;
  logic            pend, heavy, ep;
  logic [NEP-1:0]  mask;
  logic            str_heavy, str_bad, pass_data, bar_ok;
  logic            fire, acc_fire, bar_fire, clear_now;
  logic [PW-1:0]   out_q;

  mog_classify u_cls (
    .kind(in_kind), .coh(in_coh), .wt(in_wt), .ci(in_ci),
    .is_bar(is_bar), .cls(cls)
  );

  mog_track #(.TAG_W(TAG_W)) u_trk (
    .clk(clk), .rst(rst),
    .inc_v(acc_fire), .inc_tag(in_tag), .inc_cls(cls), .inc_ep(ep),
    .dec_v(ack_valid), .dec_tag(ack_tag),
    .mask(mask), .zero_cls(zc)
  );

  mog_outreg #(.W(PW)) u_out (
    .clk(clk), .rst(rst), .load(acc_fire),
    .d({in_tag, in_kind, in_coh, in_wt, in_ci}),
    .valid(mem_valid), .ready(mem_ready), .q(out_q), .free(slot_free)
  );

  assign {mem_tag, mem_kind, mem_coh, mem_wt, mem_ci} = out_q;

  assign str_heavy = (in_bstr == 2'd0) || (in_bstr == 2'd2);
  assign str_bad   = (in_bstr == 2'd3);

  always_comb begin
    if (!pend)
      pass_data = 1'b1;
    else if (heavy)
      pass_data = (cls == CLS_ICI) || (zc[CLS_LDO] && zc[CLS_STO] && zc[CLS_OTH]);
    else begin
      case (cls)
        CLS_LDO: pass_data = zc[CLS_LDO];
        CLS_STO: pass_data = zc[CLS_LDO] && zc[CLS_STO];
        default: pass_data = 1'b1;
      endcase
    end
  end

  assign bar_ok    = str_heavy ? slot_free : 1'b1;
  assign in_ready  = is_bar ? bar_ok : (pass_data && slot_free);
  assign fire      = in_valid && in_ready;
  assign acc_fire  = fire && !is_bar;
  assign bar_fire  = fire && is_bar && !str_bad;
  assign clear_now = pend && (&zc);
  assign init_stall = in_valid && is_bar && str_heavy && !slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      heavy <= 1'b0;
      mask  <= '0;
      ep    <= 1'b0;
    end else if (bar_fire && (!pend || clear_now)) begin
      pend  <= 1'b1;
      heavy <= str_heavy;
      mask  <= ep ? 2'b10 : 2'b01;
      ep    <= ~ep;
    end else if (bar_fire) begin
      heavy <= heavy | str_heavy;
      mask  <= 2'b11;
    end else if (clear_now) begin
      pend <= 1'b0;
      mask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_done <= 1'b0;
      bar_bad  <= 1'b0;
    end else begin
      bar_done <= bar_fire;
      bar_bad  <= fire && is_bar && str_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (fire && is_bar) bar_tag <= in_tag;
  end

  // R9
  bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
    bar_bad |-> $past(in_valid && in_ready && in_kind == K_BAR && in_bstr == 2'd3));
  // R10
  done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    bar_done |-> $past(in_valid && in_ready && in_kind == K_BAR && in_bstr != 2'd3));
  // R9
  done_bad_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bar_done && bar_bad));
  // R8
  heavy_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_kind == K_BAR && (in_bstr == 2'd0 || in_bstr == 2'd2))
      |-> (!mem_valid || mem_ready));
endmodule

// File: tb/sim_mem_order_gate.sv
`timescale 1ns/1ps
module sim_mem_order_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_tag = '0;
  logic [2:0] in_kind = '0;
  logic [1:0] in_bstr = '0;
  logic       in_coh = 1'b0, in_wt = 1'b0, in_ci = 1'b0;
  logic       mem_valid, mem_ready = 1'b1;
  logic [2:0] mem_tag, mem_kind;
  logic       mem_coh, mem_wt, mem_ci;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_tag = '0;
  logic       bar_done, bar_bad, init_stall;
  logic [2:0] bar_tag;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mem_order_gate #(.TAG_W(3)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_kind(in_kind), .in_bstr(in_bstr),
    .in_coh(in_coh), .in_wt(in_wt), .in_ci(in_ci),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_tag(mem_tag),
    .mem_kind(mem_kind), .mem_coh(mem_coh), .mem_wt(mem_wt), .mem_ci(mem_ci),
    .ack_valid(ack_valid), .ack_tag(ack_tag),
    .bar_done(bar_done), .bar_tag(bar_tag), .bar_bad(bar_bad),
    .init_stall(init_stall)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge
  task automatic drive(logic [2:0] k, logic [1:0] s, logic c, logic w, logic i, logic [2:0] t);
    in_kind = k; in_bstr = s; in_coh = c; in_wt = w; in_ci = i; in_tag = t;
    in_valid = 1'b1;
  endtask

  // sample ready, step one cycle, check the result of an acceptance
  task automatic expect_rdy(bit e, string req);
    logic r;
    #1;
    r = in_ready;
    chk(r == e, req, r, e);
    @(negedge clk);
    if (r) begin
      in_valid = 1'b0;
      if (in_kind != 3'd4) begin
        chk(mem_valid && mem_tag == in_tag && mem_kind == in_kind, "R2",
            {mem_valid, mem_tag}, {1'b1, in_tag});
      end else if (in_bstr == 2'd3) begin
        chk(bar_bad && !bar_done && bar_tag == in_tag, "R9", {bar_bad, bar_done}, 2);
      end else begin
        chk(bar_done && bar_tag == in_tag, "R10", {bar_done, bar_tag}, {1'b1, in_tag});
      end
    end
  endtask

  task automatic ackt(logic [2:0] t);
    ack_valid = 1'b1; ack_tag = t;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // heavy sweep variants: kind, coh, wt, ci
  function automatic logic [5:0] hv_old(int o);
    case (o)
      0: return {3'd0, 3'b100};
      1: return {3'd1, 3'b100};
      2: return {3'd2, 3'b100};
      3: return {3'd3, 3'b100};
      default: return {3'd0, 3'b101};
    endcase
  endfunction

  function automatic logic [5:0] lt_old(int o);
    case (o)
      0: return {3'd0, 3'b100};
      1: return {3'd1, 3'b100};
      2: return {3'd2, 3'b100};
      3: return {3'd0, 3'b110};
      4: return {3'd1, 3'b101};
      5: return {3'd1, 3'b000};
      default: return {3'd3, 3'b100};
    endcase
  endfunction

  function automatic logic [5:0] lt_young(int y);
    case (y)
      0: return {3'd0, 3'b100};
      1: return {3'd1, 3'b100};
      2: return {3'd2, 3'b100};
      default: return {3'd0, 3'b101};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(!mem_valid && !bar_done && !bar_bad && !init_stall, "R1",
        {mem_valid, bar_done, bar_bad, init_stall}, 0);
    drive(3'd1, 2'd0, 1, 0, 0, 3'd1);
    expect_rdy(1, "R1");
    ackt(3'd1);
    settle();

    // R3 R4 R12 heavy sweep: strengths 0 and 2
    for (int si = 0; si < 2; si++) begin
      for (int o = 0; o < 5; o++) begin
        for (int y = 0; y < 4; y++) begin
          bit blk;
          string rq;
          blk = (y != 3) && (o != 3);
          rq  = (si == 1) ? "R12" : ((o == 3 || y == 3) ? "R4" : "R3");
          v = hv_old(o);
          drive(v[5:3], 2'd0, v[2], v[1], v[0], 3'd1);
          expect_rdy(1, rq);
          drive(3'd4, si == 1 ? 2'd2 : 2'd0, 0, 0, 0, 3'd2);
          expect_rdy(1, "R10");
          drive(3'(y), 2'd0, 1, 0, 0, 3'd3);
          if (blk) begin
            expect_rdy(0, rq);
            expect_rdy(0, rq);
            ackt(3'd1);
            expect_rdy(1, rq);
          end else begin
            expect_rdy(1, rq);
            ackt(3'd1);
          end
          ackt(3'd3);
          settle();
        end
      end
    end

    // R5 R6 R7 light sweep
    for (int o = 0; o < 7; o++) begin
      for (int y = 0; y < 4; y++) begin
        bit ocov, ycov, blk;
        string rq;
        ocov = (o <= 2);
        ycov = (y <= 2);
        blk  = ocov && ycov && !(o >= 1 && y == 0);
        rq   = !ycov ? "R6" : (!ocov ? "R7" : "R5");
        v = lt_old(o);
        drive(v[5:3], 2'd0, v[2], v[1], v[0], 3'd1);
        expect_rdy(1, rq);
        drive(3'd4, 2'd1, 0, 0, 0, 3'd2);
        expect_rdy(1, "R10");
        v = lt_young(y);
        drive(v[5:3], 2'd0, v[2], v[1], v[0], 3'd3);
        if (blk) begin
          expect_rdy(0, rq);
          expect_rdy(0, rq);
          ackt(3'd1);
          expect_rdy(1, rq);
        end else begin
          expect_rdy(1, rq);
          ackt(3'd1);
        end
        ackt(3'd3);
        settle();
      end
    end

    // R9 reserved strength: no ordering
    drive(3'd1, 2'd0, 1, 0, 0, 3'd1);
    expect_rdy(1, "R9");
    drive(3'd4, 2'd3, 0, 0, 0, 3'd2);
    expect_rdy(1, "R9");
    drive(3'd1, 2'd0, 1, 0, 0, 3'd3);
    expect_rdy(1, "R9");
    ackt(3'd1);
    ackt(3'd3);
    settle();

    // R11 light then heavy merge
    drive(3'd1, 2'd0, 1, 0, 0, 3'd1);
    expect_rdy(1, "R11");
    drive(3'd4, 2'd1, 0, 0, 0, 3'd2);
    expect_rdy(1, "R11");
    drive(3'd0, 2'd0, 1, 0, 0, 3'd3);
    expect_rdy(1, "R11");
    drive(3'd4, 2'd0, 0, 0, 0, 3'd4);
    expect_rdy(1, "R11");
    drive(3'd1, 2'd0, 1, 0, 1, 3'd5);
    expect_rdy(0, "R11");
    ackt(3'd3);
    expect_rdy(0, "R11");
    ackt(3'd1);
    expect_rdy(1, "R11");
    ackt(3'd5);
    settle();

    // R8 heavy barrier waits for the port, light one does not
    mem_ready = 1'b0;
    drive(3'd0, 2'd0, 1, 0, 0, 3'd1);
    expect_rdy(1, "R8");
    drive(3'd4, 2'd1, 0, 0, 0, 3'd2);
    expect_rdy(1, "R8");
    drive(3'd4, 2'd0, 0, 0, 0, 3'd3);
    #1;
    chk(init_stall == 1'b1, "R8", init_stall, 1);
    expect_rdy(0, "R8");
    chk(mem_valid && mem_tag == 3'd1, "R2", mem_tag, 1);
    mem_ready = 1'b1;
    expect_rdy(1, "R8");
    #1;
    chk(init_stall == 1'b0 && !mem_valid, "R8", {init_stall, mem_valid}, 0);
    @(negedge clk);
    ackt(3'd1);
    settle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule